// File: doc/BRIEF.md
# Addressed Serial Code Loader for a Six-Channel Converter

This block receives 12-bit words over a three-wire serial link (data, shift clock, load strobe) and steers each word's 8-bit code into one of six holding registers. The six registered codes drive the parallel inputs of six 8-bit converters. The converters themselves are outside this block. The three serial inputs are asynchronous to the block. They are resynchronised to a system clock, and their rising edges are detected there.

Every rising edge of the shift clock moves the frame register up by one place and enters the sampled data bit at the bottom. A frame is therefore sent most significant bit first. Its upper four bits are a channel address and its lower eight bits are the code. A rising edge of the load strobe decodes the address and writes the code into the matching register. The top stage of the frame register drives a serial output, so a second loader on the same shift clock receives the same bits twelve shift clocks later. This lets several loaders be chained.

Top module: `sdac_frontend`

## Requirements
- R1: A synchronous reset sets all six channel codes and the serial output to zero.
- R2: The frame register moves by exactly one place for each rising edge of the shift clock. The bit it takes in is the data level present at that edge. Holding the shift clock high or low, or toggling data while it is high, moves nothing.
- R3: The serial output is the top stage of the 12-bit frame register. A bit entered at the bottom appears on it after 12 further shift clock rises counting its own, so a downstream loader sees each frame 12 shift clocks later.
- R4: Frame bits go out most significant bit first. Bits 11..8 are the address and bits 7..0 are the code, with bit 0 sent last. On a load, address value k (1..6) writes the code into channel k.
- R5: A load with address 0 or 7..15 leaves all six channel codes unchanged.
- R6: A load changes at most one channel code. The channels not addressed keep their values.
- R7: Only the rising edge of the load input acts. While the load input stays high, frames shifted in are not written. The next rising edge writes the current frame.
- R8: A load does not alter the frame register. The serial output and later shifting go on as though no load had happened.
- R9: When a shift clock rise and a load rise are seen in the same system cycle, the code written is the frame held before that shift, and the shift still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| serClkIn | input | 1 | Serial shift clock, asynchronous |
| serDataIn | input | 1 | Serial data, asynchronous |
| serLoadIn | input | 1 | Load strobe, asynchronous, acts on its rising edge |
| serOut | output | 1 | Top stage of the frame register, used for chaining |
| chanCodes | output | 48 | Six 8-bit channel codes; channel k occupies bits [8k-1:8k-8] |

## Verification
The shift and the load can fall in the same system cycle. Both serial edges pass through equal-length synchronisers, so rising edges driven on the same input edge produce a shift strobe and a load strobe together. The bench causes this by raising the shift clock and the load strobe at the same moment after a complete frame. It then judges two things: the addressed channel must hold the code of the frame before the extra shift, and the serial output must show that the shift still happened.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Strobes passed from the serial control to the datapath, one system cycle wide.
  typedef struct packed {
    logic shiftEn;   // rising edge of the shift clock seen
    logic shiftBit;  // data level captured with that edge
    logic loadEn;    // rising edge of the load strobe seen
  } strobe_t;

endpackage

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    serClkIn,
  input  logic    serDataIn,
  input  logic    serLoadIn,
  output strobe_t strobe
);

  localparam int TOP = SYNC_DEPTH - 1;

  logic [TOP:0] clkSync;
  logic [TOP:0] dataSync;
  logic [TOP:0] loadSync;
  logic         clkPrev;
  logic         loadPrev;

  // All three inputs pass through chains of equal length, so that edges that
  // arrive together stay together.
  generate
    if (SYNC_DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          clkSync  <= '0;
          dataSync <= '0;
          loadSync <= '0;
        end else begin
          clkSync  <= serClkIn;
          dataSync <= serDataIn;
          loadSync <= serLoadIn;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          clkSync  <= '0;
          dataSync <= '0;
          loadSync <= '0;
        end else begin
          clkSync  <= {clkSync[TOP-1:0], serClkIn};
          dataSync <= {dataSync[TOP-1:0], serDataIn};
          loadSync <= {loadSync[TOP-1:0], serLoadIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      clkPrev  <= clkSync[TOP];
      loadPrev <= loadSync[TOP];
    end
  end

  always_comb begin
    strobe.shiftEn  = clkSync[TOP] & ~clkPrev;
    strobe.shiftBit = dataSync[TOP];
    strobe.loadEn   = loadSync[TOP] & ~loadPrev;
  end

endmodule

// File: rtl/sdac_dp.sv
module sdac_dp
  import sdac_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CODE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobe_t                  strobe,
  output logic                     serOut,
  output logic [NUM_CH*CODE_W-1:0] chanCodes
);

  localparam int FRAME_W = ADDR_W + CODE_W;

  logic [FRAME_W-1:0] frame;
  logic [ADDR_W-1:0]  frameAddr;
  logic [CODE_W-1:0]  frameCode;
  logic [NUM_CH-1:0]  chanHit;

  // The frame register moves up on each shift strobe, so the first bit sent
  // ends up in the top stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      frame <= '0;
    end else if (strobe.shiftEn) begin
      frame <= {frame[FRAME_W-2:0], strobe.shiftBit};
    end
  end

  assign frameAddr = frame[FRAME_W-1 -: ADDR_W];
  assign frameCode = frame[CODE_W-1:0];
  assign serOut    = frame[FRAME_W-1];

  // Address k selects channel k; every other value selects nothing. A load
  // reads the frame before any shift in the same cycle.
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      localparam logic [ADDR_W-1:0] SEL = ADDR_W'(c + 1);
      logic [CODE_W-1:0] codeReg;

      assign chanHit[c] = strobe.loadEn && (frameAddr == SEL);

      always_ff @(posedge clk) begin
        if (rst) begin
          codeReg <= '0;
        end else if (chanHit[c]) begin
          codeReg <= frameCode;
        end
      end

      assign chanCodes[c*CODE_W +: CODE_W] = codeReg;
    end
  endgenerate

endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend
  import sdac_pkg::*;
#(
  parameter int NUM_CH     = 6,
  parameter int CODE_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     serClkIn,
  input  logic                     serDataIn,
  input  logic                     serLoadIn,
  output logic                     serOut,
  output logic [NUM_CH*CODE_W-1:0] chanCodes
);

  strobe_t strobe;

  sdac_ctrl #(
    .SYNC_DEPTH(SYNC_DEPTH)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .serClkIn (serClkIn),
    .serDataIn(serDataIn),
    .serLoadIn(serLoadIn),
    .strobe   (strobe)
  );

  sdac_dp #(
    .NUM_CH(NUM_CH),
    .CODE_W(CODE_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .serOut   (serOut),
    .chanCodes(chanCodes)
  );

endmodule

// File: rtl/sdac_checker.sv
module sdac_checker #(
  parameter int NUM_CH = 6,
  parameter int CODE_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     shiftEn,
  input logic                     loadEn,
  input logic                     serOut,
  input logic [NUM_CH*CODE_W-1:0] chanCodes
);

  logic [NUM_CH*CODE_W-1:0] codesPrev;
  logic [NUM_CH-1:0]        chanChanged;

  always_ff @(posedge clk) codesPrev <= chanCodes;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
      assign chanChanged[c] = chanCodes[c*CODE_W +: CODE_W] != codesPrev[c*CODE_W +: CODE_W];
    end
  endgenerate

  // R1: one cycle of reset leaves codes and serial output cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (chanCodes == '0 && serOut == 1'b0));

  // R2: without a shift strobe the serial output holds
  p_hold_no_shift_r2: assert property (@(posedge clk) disable iff (rst)
    !shiftEn |=> $stable(serOut));

  // R5: codes move only after a load strobe
  p_codes_need_load_r5: assert property (@(posedge clk) disable iff (rst)
    !loadEn |=> $stable(chanCodes));

  // R6: at most one channel changes in any cycle
  p_single_channel_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chanChanged));

  // R8: a load alone does not disturb the serial output
  p_load_keeps_frame_r8: assert property (@(posedge clk) disable iff (rst)
    (loadEn && !shiftEn) |=> $stable(serOut));

endmodule

bind sdac_frontend sdac_checker #(
  .NUM_CH(NUM_CH),
  .CODE_W(CODE_W)
) u_sdac_checker (
  .clk      (clk),
  .rst      (rst),
  .shiftEn  (strobe.shiftEn),
  .loadEn   (strobe.loadEn),
  .serOut   (serOut),
  .chanCodes(chanCodes)
);

// File: tb/test_sdac_frontend.sv
module test_sdac_frontend;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 6;
  localparam int CW         = 8;
  localparam int SETTLE     = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serLoad = 1'b0;
  logic serOut;
  logic [NCH*CW-1:0] chanCodes;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdac_frontend i_sdac_frontend (
    .clk      (clk),
    .rst      (rst),
    .serClkIn (serClk),
    .serDataIn(serData),
    .serLoadIn(serLoad),
    .serOut   (serOut),
    .chanCodes(chanCodes)
  );

  typedef struct {
    int              req;
    bit              isSer;
    logic            expSer;
    logic [NCH*CW-1:0] expCodes;
  } item_t;

  item_t q[$];
  event  sampleEv;
  int    compared   = 0;
  int    mismatched = 0;

  logic [11:0]       model    = '0;
  logic [NCH*CW-1:0] expCodes = '0;

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    forever begin
      @(sampleEv);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        compared++;
        if (it.isSer) begin
          if (serOut !== it.expSer) begin
            mismatched++;
            $display("FAIL R%0d serOut actual=%b expected=%b", it.req, serOut, it.expSer);
          end
        end else if (chanCodes !== it.expCodes) begin
          mismatched++;
          $display("FAIL R%0d chanCodes actual=%h expected=%h", it.req, chanCodes, it.expCodes);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkSer(input int req);
    item_t it;
    it.req = req; it.isSer = 1'b1; it.expSer = model[11]; it.expCodes = '0;
    q.push_back(it);
    ->sampleEv;
  endtask

  task automatic checkCodes(input int req);
    item_t it;
    it.req = req; it.isSer = 1'b0; it.expSer = 1'b0; it.expCodes = expCodes;
    q.push_back(it);
    ->sampleEv;
  endtask

  // Expected effect of a load on the frame f (address in 11..8, code in 7..0).
  function automatic void applyLoad(input logic [11:0] f);
    int a;
    a = int'(f[11:8]);
    if (a >= 1 && a <= NCH) expCodes[(a-1)*CW +: CW] = f[7:0];
  endfunction

  task automatic shiftBit(input logic b);
    serData = b;
    idle(SETTLE);
    serClk = 1'b1;
    idle(SETTLE);
    serClk = 1'b0;
    idle(SETTLE);
    model = {model[10:0], b};
  endtask

  task automatic sendFrame(input logic [3:0] a, input logic [7:0] c, input int chkReq);
    logic [11:0] f;
    f = {a, c};
    for (int i = 11; i >= 0; i--) begin
      shiftBit(f[i]);
      if (chkReq != 0) checkSer(chkReq);
    end
  endtask

  task automatic pulseLoad();
    serLoad = 1'b1;
    idle(SETTLE);
    serLoad = 1'b0;
    idle(SETTLE);
    applyLoad(model);
  endtask

  initial begin
    idle(SETTLE);
    rst = 1'b0;
    idle(2);
    checkCodes(1);   // R1 reset state
    checkSer(1);

    // R3: frame with top bit set, watched bit by bit from the zero state
    sendFrame(4'h9, 8'h00, 3);
    pulseLoad();
    checkCodes(5);   // R5 address 9 writes nothing
    checkSer(8);     // R8 load leaves frame

    // R3/R4: old frame streams out while a new one enters
    sendFrame(4'h1, 8'hA5, 3);
    pulseLoad();
    checkCodes(4);   // R4 channel 1 gets A5
    sendFrame(4'h6, 8'h3C, 0);
    pulseLoad();
    checkCodes(6);   // R6 only channel 6 changes
    sendFrame(4'h3, 8'hF0, 0);
    pulseLoad();
    checkCodes(4);   // R4 channel 3

    // R5: invalid addresses
    sendFrame(4'h0, 8'hFF, 0); pulseLoad(); checkCodes(5);
    sendFrame(4'h7, 8'h11, 0); pulseLoad(); checkCodes(5);
    sendFrame(4'hF, 8'hEE, 0); pulseLoad(); checkCodes(5);

    // R7: load held high acts once
    sendFrame(4'h2, 8'h5A, 0);
    serLoad = 1'b1;
    idle(SETTLE);
    applyLoad(model);
    checkCodes(7);
    sendFrame(4'h2, 8'hC3, 0);
    checkCodes(7);   // still 5A while load stays high
    serLoad = 1'b0;
    idle(SETTLE);
    checkCodes(7);
    pulseLoad();
    checkCodes(7);   // new edge writes C3

    // R8: shifting continues undisturbed after the load
    checkSer(8);
    for (int i = 0; i < 3; i++) begin
      shiftBit(1'(i & 1));
      checkSer(8);
    end

    // R2: clock held high while data toggles; only the level at the rise enters
    serData = 1'b1;
    idle(SETTLE);
    serClk = 1'b1;
    idle(SETTLE);
    for (int i = 0; i < 4; i++) begin
      serData = ~serData;
      idle(SETTLE);
    end
    idle(4 * SETTLE);
    serClk = 1'b0;
    idle(SETTLE);
    model = {model[10:0], 1'b1};
    checkSer(2);
    for (int i = 0; i < 11; i++) shiftBit(1'b0);
    checkSer(2);     // the captured 1 has reached the top

    // R9: shift and load rise together
    sendFrame(4'h4, 8'h9C, 0);
    serData = 1'b1;
    idle(SETTLE);
    serClk  = 1'b1;
    serLoad = 1'b1;
    idle(SETTLE);
    serClk  = 1'b0;
    serLoad = 1'b0;
    idle(SETTLE);
    applyLoad(model);
    model = {model[10:0], 1'b1};
    checkCodes(9);
    checkSer(9);

    // R1: reset in mid-run clears everything
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(2);
    model    = '0;
    expCodes = '0;
    checkCodes(1);
    checkSer(1);

    idle(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule